// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block runs a single I2C master transaction of one to four bytes on behalf of a control register. A write of the control word starts a transfer. The block then drives a byte-level bus engine through start-with-address, byte write, byte read and stop requests. Each request is held until the engine answers with an acknowledge or a not-acknowledge. The bytes come from a small data buffer, and read bytes go back into the same buffer. A chain flag and a repeated-start flag decide whether the bus is released after each byte or held open across bytes and across commands.

When the sequence ends, the block records how many bytes completed. It keeps an error flag and a transfer-aborted flag, and it pulses a done strobe plus an optional completion interrupt. A halt command releases a bus that an earlier command left held, and it can raise a halt interrupt. Bit-level SCL/SDA timing and the register bus decode belong to other blocks.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset, `busy`, `bus_held`, `err_flag`, `abort_flag`, `done`, `done_irq` and `halt_irq` are 0, and `ctrl_word`, `xfer_count` and `data_out` are all zero.
- R2: A command is taken only in a cycle where `cmd_wr` is high and `busy` is low. It stores `cmd_word` into `ctrl_word` with bit 0 cleared. While `busy` is high, `cmd_wr` has no effect on `ctrl_word` or on the request sequence.
- R3: Bit 0 of the command (go) starts a transfer of N bytes, where N is `cmd_word[5:4]` plus 1. Engine operations are encoded on `eng_op` as 0 start-with-address, 1 write byte, 2 read byte and 3 stop. Each request stays asserted until `eng_ack` or `eng_nack` arrives.
- R4: The address presented with a start request is `addr_reg[7:1]`. `eng_rd` equals command bit 1. Command bit 6 (10-bit addressing request) has no effect on the address or on the sequence.
- R5: Before each byte, a start request is issued only if the bus is not held. If the bus is held, the byte request follows directly.
- R6: After each acknowledged byte, a stop is issued when command bit 3 (repeated start) is set or bit 2 (chain) is clear. Otherwise the bus stays held. `bus_held` rises on an acknowledged start and falls when a stop completes.
- R7: Byte i is written from `data_in[8i+7:8i]`, which is captured when the command is taken. A read byte i replaces that same lane, and `data_out` shows all four lanes.
- R8: A not-acknowledge on a start sets `err_flag` and `abort_flag`. It ends the sequence with no stop, and the bus remains not held.
- R9: A not-acknowledge on a byte sets `err_flag` and `abort_flag` and ends the sequence with no stop. That byte is not counted, and the bus stays held.
- R10: An acknowledged start clears `err_flag`. A transfer that needs no start phase leaves `err_flag` unchanged. A new go command clears `abort_flag`.
- R11: When a transfer ends, `xfer_count` takes the number of acknowledged bytes. In the cycle where `busy` first falls, `done` pulses. `done_irq` pulses with it only if that count is nonzero and `done_irq_en` is high.
- R12: A command with bit 7 (halt) set while `bus_held` is high issues a single stop and ignores bit 0. It then pulses `halt_irq` if `halt_irq_en` is high, and `xfer_count` is unchanged. A halt while the bus is free is treated as an ordinary command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Control word write strobe |
| cmd_word | input | 8 | Control word |
| addr_reg | input | 8 | Target address register; bits 7:1 are the 7-bit address |
| data_in | input | 32 | Byte lanes loaded into the buffer on a go command |
| done_irq_en | input | 1 | Enables the completion interrupt |
| halt_irq_en | input | 1 | Enables the halt interrupt |
| eng_req | output | 1 | Engine request valid |
| eng_op | output | 2 | Engine operation (0 start, 1 write, 2 read, 3 stop) |
| eng_addr | output | 7 | Target address for a start request |
| eng_rd | output | 1 | Direction bit for the address phase |
| eng_wdata | output | 8 | Byte to write |
| eng_ack | input | 1 | Engine completed the request |
| eng_nack | input | 1 | Engine reports not-acknowledge or failure |
| eng_rdata | input | 8 | Byte received, valid with `eng_ack` on a read |
| busy | output | 1 | Sequence in progress |
| bus_held | output | 1 | Bus opened by this block and not yet stopped |
| ctrl_word | output | 8 | Stored control word |
| err_flag | output | 1 | Error flag |
| abort_flag | output | 1 | Transfer-aborted flag |
| xfer_count | output | 3 | Bytes completed in the last transfer |
| data_out | output | 32 | Data buffer contents |
| done | output | 1 | One-cycle end-of-transfer pulse |
| done_irq | output | 1 | Completion interrupt pulse |
| halt_irq | output | 1 | Halt interrupt pulse |

## Verification
Transfers are run with single-byte writes and with four-byte writes that stop after every byte. Chained reads that hold the bus are followed by a halt, and a chained read with repeated start reopens the address phase before each byte. Together these separate the start-only-when-free rule from the stop rule. Not-acknowledges are injected on an address and on a middle data byte, which tells the two abort paths apart through the bus-held state, the byte count and the error flag of a following headless transfer. Commands written while busy, a halt on a free bus and a command without the go bit check what must be ignored.

// File: rtl/i2c_seq_pkg.sv
// Shared types and control-word bit positions for the transfer sequencer.
// Assumes the byte-count field sits at bit 4 and is at most 2 bits wide.
package i2c_seq_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } eng_op_t;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ADDR = 3'd1,
        S_DATA = 3'd2,
        S_STOP = 3'd3,
        S_FIN  = 3'd4,
        S_HALT = 3'd5
    } seq_state_t;

    localparam int CB_GO     = 0;
    localparam int CB_READ   = 1;
    localparam int CB_CHAIN  = 2;
    localparam int CB_RSTART = 3;
    localparam int CB_COUNT  = 4;
    localparam int CB_HALT   = 7;
endpackage

// File: rtl/i2c_seq_buf.sv
// Byte-lane data buffer shared by the write and read directions.
// Loads every lane at once when a transfer starts and replaces one lane per
// received byte. Assumes load and lane write never coincide.
module i2c_seq_buf #(
    parameter int NBYTES = 4,
    parameter int IDX_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [NBYTES*8-1:0]   load_data,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_byte,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_byte,
    output logic [NBYTES*8-1:0]   contents
);
    logic [7:0] lane_q [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        // Hold one lane: bulk load on start, single replace on a read byte.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q[g] <= 8'h00;
            end else if (load) begin
                lane_q[g] <= load_data[g*8 +: 8];
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                lane_q[g] <= wr_byte;
            end
        end
        assign contents[g*8 +: 8] = lane_q[g];
    end

    // Present the lane selected for the next write request.
    always_comb rd_byte = lane_q[rd_idx];
endmodule

// File: rtl/i2c_seq_fsm.sv
// Sequencer state machine. Accepts a control word when idle. It walks the
// address / byte / stop requests of one transfer, or the single stop of a
// halt, and keeps the error, abort, count and bus-held state. Assumes the
// engine answers each held request with a one-cycle ack or nack.
module i2c_seq_fsm
    import i2c_seq_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter int IDX_W  = 2,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_word,
    input  logic              done_irq_en,
    input  logic              halt_irq_en,
    input  logic              eng_ack,
    input  logic              eng_nack,
    output logic              eng_req,
    output logic [1:0]        eng_op,
    output logic              eng_rd,
    output logic              busy,
    output logic              bus_held,
    output logic [7:0]        ctrl_word,
    output logic              err_flag,
    output logic              abort_flag,
    output logic [CNT_W-1:0]  xfer_count,
    output logic              done,
    output logic              done_irq,
    output logic              halt_irq,
    output logic              buf_load,
    output logic              buf_wr,
    output logic [IDX_W-1:0]  buf_idx
);
    seq_state_t        state_q, state_d;
    logic [7:0]        ctrl_q;
    logic              held_q, err_q, abort_q, done_q, halt_irq_q;
    logic [CNT_W-1:0]  sent_q, cnt_q;

    logic              accept, halt_go, start_go, stop_each, resp;
    logic [CNT_W-1:0]  n_bytes, sent_next;

    // Decode the command and the per-byte stop policy.
    always_comb begin
        accept    = cmd_wr && (state_q == S_IDLE);
        halt_go   = accept && cmd_word[CB_HALT] && held_q;
        start_go  = accept && !halt_go && cmd_word[CB_GO];
        stop_each = ctrl_q[CB_RSTART] || !ctrl_q[CB_CHAIN];
        n_bytes   = CNT_W'(ctrl_q[CB_COUNT +: IDX_W]) + CNT_W'(1);
        sent_next = sent_q + CNT_W'(1);
        resp      = eng_ack || eng_nack;
    end

    // Choose the next step of the sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (halt_go)       state_d = S_HALT;
                else if (start_go) state_d = held_q ? S_DATA : S_ADDR;
            end
            S_ADDR: begin
                if (eng_ack)       state_d = S_DATA;
                else if (eng_nack) state_d = S_FIN;
            end
            S_DATA: begin
                if (eng_nack)                   state_d = S_FIN;
                else if (eng_ack && stop_each)  state_d = S_STOP;
                else if (eng_ack)               state_d = (sent_next == n_bytes) ? S_FIN : S_DATA;
            end
            S_STOP: begin
                if (resp) state_d = (sent_q == n_bytes) ? S_FIN : S_ADDR;
            end
            S_HALT:  if (resp) state_d = S_IDLE;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Advance the state and all sequence-owned flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            ctrl_q     <= 8'h00;
            held_q     <= 1'b0;
            err_q      <= 1'b0;
            abort_q    <= 1'b0;
            sent_q     <= '0;
            cnt_q      <= '0;
            done_q     <= 1'b0;
            halt_irq_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            done_q     <= (state_q == S_FIN);
            halt_irq_q <= (state_q == S_HALT) && resp && halt_irq_en;
            if (accept) ctrl_q <= {cmd_word[7:1], 1'b0};
            if (start_go) begin
                abort_q <= 1'b0;
                sent_q  <= '0;
            end
            if (state_q == S_ADDR && eng_ack) begin
                held_q <= 1'b1;
                err_q  <= 1'b0;
            end
            if ((state_q == S_ADDR || state_q == S_DATA) && eng_nack) begin
                err_q   <= 1'b1;
                abort_q <= 1'b1;
            end
            if (state_q == S_DATA && eng_ack) sent_q <= sent_next;
            if ((state_q == S_STOP || state_q == S_HALT) && resp) held_q <= 1'b0;
            if (state_q == S_FIN) cnt_q <= sent_q;
        end
    end

    // Drive the engine request and the status outputs.
    always_comb begin
        eng_req = (state_q == S_ADDR) || (state_q == S_DATA) ||
                  (state_q == S_STOP) || (state_q == S_HALT);
        unique case (state_q)
            S_ADDR:  eng_op = OP_START;
            S_DATA:  eng_op = ctrl_q[CB_READ] ? OP_READ : OP_WRITE;
            default: eng_op = OP_STOP;
        endcase
        eng_rd     = ctrl_q[CB_READ];
        busy       = (state_q != S_IDLE);
        bus_held   = held_q;
        ctrl_word  = ctrl_q;
        err_flag   = err_q;
        abort_flag = abort_q;
        xfer_count = cnt_q;
        done       = done_q;
        done_irq   = done_q && (cnt_q != '0) && done_irq_en;
        halt_irq   = halt_irq_q;
        buf_load   = start_go;
        buf_wr     = (state_q == S_DATA) && eng_ack && ctrl_q[CB_READ];
        buf_idx    = sent_q[IDX_W-1:0];
    end
endmodule

// File: rtl/i2c_xfer_seq.sv
// Top of the I2C master transfer sequencer. Joins the state machine to the
// byte buffer and forms the 7-bit target address. Assumes NBYTES is at most
// 4, so the count field fits in control bits 5:4. Command bit 6 is stored but
// never used: only 7-bit addressing is supported.
module i2c_xfer_seq #(
    parameter int NBYTES = 4,
    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int CNT_W = $clog2(NBYTES + 1),
    localparam int BUF_W = NBYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_word,
    input  logic [7:0]        addr_reg,
    input  logic [BUF_W-1:0]  data_in,
    input  logic              done_irq_en,
    input  logic              halt_irq_en,
    output logic              eng_req,
    output logic [1:0]        eng_op,
    output logic [6:0]        eng_addr,
    output logic              eng_rd,
    output logic [7:0]        eng_wdata,
    input  logic              eng_ack,
    input  logic              eng_nack,
    input  logic [7:0]        eng_rdata,
    output logic              busy,
    output logic              bus_held,
    output logic [7:0]        ctrl_word,
    output logic              err_flag,
    output logic              abort_flag,
    output logic [CNT_W-1:0]  xfer_count,
    output logic [BUF_W-1:0]  data_out,
    output logic              done,
    output logic              done_irq,
    output logic              halt_irq
);
    logic             buf_load, buf_wr;
    logic [IDX_W-1:0] buf_idx;
    logic             unused_addr_lsb;

    // The target address is the register shifted right by one.
    assign eng_addr        = addr_reg[7:1];
    assign unused_addr_lsb = addr_reg[0];

    i2c_seq_fsm #(.NBYTES(NBYTES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .done_irq_en(done_irq_en), .halt_irq_en(halt_irq_en),
        .eng_ack(eng_ack), .eng_nack(eng_nack),
        .eng_req(eng_req), .eng_op(eng_op), .eng_rd(eng_rd),
        .busy(busy), .bus_held(bus_held), .ctrl_word(ctrl_word),
        .err_flag(err_flag), .abort_flag(abort_flag), .xfer_count(xfer_count),
        .done(done), .done_irq(done_irq), .halt_irq(halt_irq),
        .buf_load(buf_load), .buf_wr(buf_wr), .buf_idx(buf_idx)
    );

    i2c_seq_buf #(.NBYTES(NBYTES), .IDX_W(IDX_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .load(buf_load), .load_data(data_in),
        .wr_en(buf_wr), .wr_idx(buf_idx), .wr_byte(eng_rdata),
        .rd_idx(buf_idx), .rd_byte(eng_wdata), .contents(data_out)
    );
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
// Protocol checker for the transfer sequencer, bound to every instance of
// the top module. It observes ports only.
module i2c_xfer_seq_chk #(
    parameter int NBYTES = 4,
    localparam int CNT_W = $clog2(NBYTES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr,
    input logic              eng_req,
    input logic [1:0]        eng_op,
    input logic              eng_ack,
    input logic              eng_nack,
    input logic              busy,
    input logic              bus_held,
    input logic [7:0]        ctrl_word,
    input logic              err_flag,
    input logic              abort_flag,
    input logic [CNT_W-1:0]  xfer_count,
    input logic              done,
    input logic              halt_irq
);
    assert_ignore_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> $stable(ctrl_word));

    assert_start_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_op == 2'd0) |-> !bus_held);

    assert_stop_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_op == 2'd3 && eng_ack) |=> !bus_held);

    assert_nack_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_op != 2'd3 && eng_nack) |=> (err_flag && abort_flag));

    assert_addr_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_op == 2'd0 && eng_ack) |=> (!err_flag && bus_held));

    assert_done_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && xfer_count <= CNT_W'(NBYTES)));

    assert_halt_free_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halt_irq |-> (!bus_held && !busy));
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk #(.NBYTES(NBYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .eng_req(eng_req),
    .eng_op(eng_op), .eng_ack(eng_ack), .eng_nack(eng_nack), .busy(busy),
    .bus_held(bus_held), .ctrl_word(ctrl_word), .err_flag(err_flag),
    .abort_flag(abort_flag), .xfer_count(xfer_count), .done(done),
    .halt_irq(halt_irq)
);

// File: tb/sim_i2c_xfer_seq.sv
// Bench: a behavioural engine responder and a queue-based reference model of
// the expected request sequence and end-of-transfer state.
module sim_i2c_xfer_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_word = 8'h00;
    logic [7:0]  addr_reg = 8'h00;
    logic [31:0] data_in = 32'h0;
    logic        done_irq_en = 1'b1;
    logic        halt_irq_en = 1'b1;
    logic        eng_req, eng_rd;
    logic [1:0]  eng_op;
    logic [6:0]  eng_addr;
    logic [7:0]  eng_wdata;
    logic        eng_ack = 1'b0;
    logic        eng_nack = 1'b0;
    logic [7:0]  eng_rdata = 8'h00;
    logic        busy, bus_held, err_flag, abort_flag, done, done_irq, halt_irq;
    logic [7:0]  ctrl_word;
    logic [2:0]  xfer_count;
    logic [31:0] data_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_xfer_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .addr_reg(addr_reg), .data_in(data_in), .done_irq_en(done_irq_en),
        .halt_irq_en(halt_irq_en), .eng_req(eng_req), .eng_op(eng_op),
        .eng_addr(eng_addr), .eng_rd(eng_rd), .eng_wdata(eng_wdata),
        .eng_ack(eng_ack), .eng_nack(eng_nack), .eng_rdata(eng_rdata),
        .busy(busy), .bus_held(bus_held), .ctrl_word(ctrl_word),
        .err_flag(err_flag), .abort_flag(abort_flag), .xfer_count(xfer_count),
        .data_out(data_out), .done(done), .done_irq(done_irq), .halt_irq(halt_irq)
    );

    int n_checks = 0;
    int n_fail = 0;
    int exp_op[$];
    int exp_dat[$];
    int nack_at = -1;
    int op_seen = 0;
    int exp_addr = 0;
    int exp_rd = 0;
    bit pend = 1'b0;
    int wait_c = 0;
    int cur_idx = 0;
    int cur_op = 0;
    int m_held = 0, m_err = 0, m_abort = 0, m_cnt = 0;
    logic [7:0] m_buf [4];
    logic [7:0] m_ctrl = 8'h00;

    task automatic chk(input string tag, input string what, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Engine responder: picks up each new request, checks it against the
    // model queue, and answers one cycle later.
    initial begin
        forever begin
            @(negedge clk);
            if (eng_ack || eng_nack) begin
                eng_ack  = 1'b0;
                eng_nack = 1'b0;
                pend     = 1'b0;
            end else if (rst_n && eng_req) begin
                if (!pend) begin
                    pend    = 1'b1;
                    wait_c  = 1;
                    cur_idx = op_seen;
                    cur_op  = int'(eng_op);
                    op_seen++;
                    if (exp_op.size() == 0) begin
                        chk("R2", "unexpected request op", cur_op, -1);
                    end else begin
                        int eo, ed;
                        string tg;
                        eo = exp_op.pop_front();
                        ed = exp_dat.pop_front();
                        tg = (eo == 0) ? "R5" : (eo == 3) ? "R6" : "R3";
                        chk(tg, "request op", cur_op, eo);
                        if (eo == 0) begin
                            chk("R4", "target address", int'(eng_addr), exp_addr);
                            chk("R4", "direction bit", int'(eng_rd), exp_rd);
                        end
                        if (eo == 1) chk("R7", "write byte", int'(eng_wdata), ed);
                    end
                end
                if (wait_c == 0) begin
                    if (cur_idx == nack_at) eng_nack = 1'b1;
                    else eng_ack = 1'b1;
                    eng_rdata = 8'hC0 + 8'(cur_idx);
                end else begin
                    wait_c--;
                end
            end
        end
    end

    // One command: build the expected requests, issue, wait, compare.
    task automatic run(input logic [7:0] cmd, input logic [7:0] addr,
                       input logic [31:0] din, input int nk, input bit poke,
                       input string ftag);
        bit halt_path, start_path, ab;
        int n, k, guard;
        exp_op.delete();
        exp_dat.delete();
        nack_at    = nk;
        op_seen    = 0;
        exp_addr   = int'(addr[7:1]);
        exp_rd     = int'(cmd[1]);
        halt_path  = cmd[7] && (m_held != 0);
        start_path = !halt_path && cmd[0];
        m_ctrl     = cmd & 8'hFE;
        if (halt_path) begin
            exp_op.push_back(3); exp_dat.push_back(-1);
            m_held = 0;
        end else if (start_path) begin
            m_abort = 0;
            m_cnt   = 0;
            for (int i = 0; i < 4; i++) m_buf[i] = din[i*8 +: 8];
            n  = int'(cmd[5:4]) + 1;
            k  = 0;
            ab = 1'b0;
            for (int i = 0; i < n && !ab; i++) begin
                if (m_held == 0) begin
                    exp_op.push_back(0); exp_dat.push_back(-1);
                    if (k == nk) begin m_err = 1; m_abort = 1; ab = 1'b1; end
                    else begin m_err = 0; m_held = 1; end
                    k++;
                end
                if (!ab) begin
                    exp_op.push_back(cmd[1] ? 2 : 1);
                    exp_dat.push_back(cmd[1] ? -1 : int'(m_buf[i]));
                    if (k == nk) begin m_err = 1; m_abort = 1; ab = 1'b1; end
                    else begin
                        if (cmd[1]) m_buf[i] = 8'hC0 + 8'(k);
                        m_cnt++;
                    end
                    k++;
                    if (!ab && (cmd[3] || !cmd[2])) begin
                        exp_op.push_back(3); exp_dat.push_back(-1);
                        k++;
                        m_held = 0;
                    end
                end
            end
        end
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word = cmd; addr_reg = addr; data_in = din;
        @(negedge clk);
        cmd_wr = 1'b0;
        guard = 0;
        while (busy && guard < 2000) begin
            if (busy) chk("R2", "busy during sequence", int'(busy), 1);
            if (poke && guard == 2) begin cmd_wr = 1'b1; cmd_word = 8'hFE; end
            else cmd_wr = 1'b0;
            @(negedge clk);
            guard++;
        end
        cmd_wr = 1'b0;
        chk("R3", "sequence finished in time", (guard < 2000) ? 1 : 0, 1);
        chk("R3", "all expected requests issued", exp_op.size(), 0);
        chk("R11", "done pulse", int'(done), start_path ? 1 : 0);
        chk("R11", "done_irq", int'(done_irq), (start_path && m_cnt > 0 && done_irq_en) ? 1 : 0);
        chk("R12", "halt_irq", int'(halt_irq), (halt_path && halt_irq_en) ? 1 : 0);
        chk("R11", "xfer_count", int'(xfer_count), m_cnt);
        chk(ftag, "err_flag", int'(err_flag), m_err);
        chk(ftag, "abort_flag", int'(abort_flag), m_abort);
        chk("R6", "bus_held", int'(bus_held), m_held);
        chk("R2", "ctrl_word", int'(ctrl_word), int'(m_ctrl));
        chk("R7", "data_out", int'(data_out), int'({m_buf[3], m_buf[2], m_buf[1], m_buf[0]}));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_buf[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "bus_held", int'(bus_held), 0);
        chk("R1", "err/abort", int'({err_flag, abort_flag}), 0);
        chk("R1", "pulses", int'({done, done_irq, halt_irq}), 0);
        chk("R1", "ctrl_word", int'(ctrl_word), 0);
        chk("R1", "xfer_count", int'(xfer_count), 0);
        chk("R1", "data_out", int'(data_out), 0);

        run(8'h01, 8'hA4, 32'h44332211, -1, 1'b0, "R10");   // 1-byte write
        run(8'h31, 8'h3C, 32'hDDCCBBAA, -1, 1'b0, "R10");   // 4 bytes, stop each (R3)
        run(8'h67, 8'h91, 32'h87654321, -1, 1'b0, "R10");   // 3 chained reads, bit 6 set (R4)
        run(8'h81, 8'h00, 32'h0, -1, 1'b0, "R12");          // halt on held bus
        run(8'h1F, 8'h22, 32'h0, -1, 1'b0, "R10");          // chain + repeated start reads
        run(8'h11, 8'h50, 32'h00005566, 0, 1'b0, "R8");     // address nack
        run(8'h01, 8'h50, 32'h00000077, -1, 1'b0, "R10");   // clean ack clears error
        run(8'h25, 8'h50, 32'h00332211, 2, 1'b0, "R9");     // nack on 2nd byte
        run(8'h01, 8'h50, 32'h000000EE, -1, 1'b0, "R10");   // no start phase: error kept
        run(8'h35, 8'h7E, 32'h0F0E0D0C, -1, 1'b1, "R2");    // command while busy ignored
        run(8'h80, 8'h00, 32'h0, -1, 1'b0, "R12");          // halt releases bus
        run(8'h81, 8'h12, 32'h00000099, -1, 1'b0, "R12");   // halt on free bus acts as go
        run(8'h04, 8'h12, 32'h12345678, -1, 1'b0, "R2");    // no go bit: store only
        done_irq_en = 1'b0;
        run(8'h11, 8'h12, 32'h0000A5B6, -1, 1'b0, "R11");   // completion irq masked
        halt_irq_en = 1'b0;
        run(8'h05, 8'h12, 32'h000000C3, -1, 1'b0, "R10");   // chain: bus left held
        run(8'h80, 8'h00, 32'h0, -1, 1'b0, "R12");          // halt irq masked

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule